// File: doc/BRIEF.md
# Speculative Branch History Repair Queue

This block keeps, for one hardware thread, an ordered list of the branch predictions that are still in flight. Fetch adds one record per predicted branch. The record holds the branch sequence number, its PC, and the predicted direction. It also holds the return-stack slot and address the prediction consumed, the call/return kind, whether the branch pushed or used the return stack, and an opaque tag that identifies the direction predictor's private history.

When branches retire, the block walks the queue from the oldest end. For each retired record it tells the direction predictor either to train on the record or to drop it. When the pipeline flushes, the block walks the queue from the youngest end. For each record it removes, it tells the predictor to discard that record's history and undoes whatever the record did to the return stack. On a misprediction it then repairs the mispredicting record in place so that the record can commit later. The direction predictor, the return stack and the target buffer live outside the block. The block reaches them only through one-cycle command strobes.

Walks handle one record per clock. While a walk is running, the block reports itself busy and refuses both new records and new commands.

Top module: `hist_repair_queue`

## Requirements
- R1: After reset the queue is empty and `insReady` is 1. A record presented with `insValid` while `insReady` is 1 is appended at the young end. `insReady` is 0 while the queue holds DEPTH (16) records, and a record presented then is dropped.
- R2: A commit request with a done number removes records from the old end, oldest first, one per cycle, while the oldest sequence number is less than or equal to the done number.
- R3: Each committed record produces a predictor command with the record's PC, tag and predicted direction. `predOp` is 0 (train) if the record was never marked squashed and 1 (retire-squashed) if it was. `predSquashed` is 0 on both.
- R4: A squash request removes records from the young end, youngest first, one per cycle, while the youngest sequence number is greater than the request's number. Each removed record produces a predictor command with `predOp` = 2 (discard), carrying its PC, tag and predicted direction.
- R5: In the same cycle as each removal by squash, the block acts on the return stack. If the record used the stack, it issues a restore (`stkOp` = 0) with the saved slot and address. Otherwise, if the record is a call that pushed, it issues a pop (`stkOp` = 1, slot and address 0). Otherwise it issues no stack command.
- R6: With `squashMispred` set, once the walk stops the youngest surviving record is repaired in one cycle. The block issues a train command (`predOp` = 0) carrying the actual direction with `predSquashed` = 1, and marks the record as squashed, so that it later commits as retire-squashed.
- R7: `mispredCount` increments on every accepted misprediction request, even when the queue is empty. `stackWrongCount` increments on every repair of a record that had used the stack.
- R8: In a repair with the actual direction taken, a return that had not used the stack issues a stack pop and becomes marked as having used the stack. In the same cycle the target buffer receives an update with the record's PC and the corrected target.
- R9: In a repair with the actual direction not taken, a record that used the stack issues a restore with its saved slot and address and loses its used-stack mark. Otherwise, a call that pushed issues a pop and loses its pushed mark. Either way, a later squash of that record issues no stack command.
- R10: A misprediction that arrives when the queue is (or becomes) empty issues no predictor, stack or target command.
- R11: `busy` is 1 from the cycle after a commit or squash is accepted until its walk ends. While `busy` is 1, `insReady` is 0 and inserts are dropped. If several requests arrive in the same idle cycle, squash wins over commit, and both win over insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | New record offered |
| insReady | output | 1 | Record will be accepted this cycle |
| insSeq | input | 16 | Sequence number of new record |
| insPc | input | 32 | Branch PC |
| insTaken | input | 1 | Predicted direction |
| insStkIdx | input | 4 | Return-stack slot consumed |
| insStkVal | input | 32 | Return-stack address consumed |
| insUsedStack | input | 1 | Prediction took its target from the stack |
| insPushed | input | 1 | Prediction pushed the stack |
| insWasCall | input | 1 | Branch is a call |
| insWasReturn | input | 1 | Branch is a return |
| insTag | input | 8 | Opaque predictor history tag |
| commitValid | input | 1 | Commit request |
| commitSeq | input | 16 | Done sequence number |
| squashValid | input | 1 | Squash request |
| squashSeq | input | 16 | Squash boundary sequence number |
| squashMispred | input | 1 | Squash is a misprediction needing repair |
| actTaken | input | 1 | Actual direction of mispredicted branch |
| corrTarget | input | 32 | Corrected target |
| busy | output | 1 | Walk in progress |
| predValid | output | 1 | Predictor command strobe |
| predOp | output | 2 | 0 train, 1 retire-squashed, 2 discard |
| predPc | output | 32 | PC of record |
| predTaken | output | 1 | Direction sent to predictor |
| predSquashed | output | 1 | Training caused by misprediction |
| predTag | output | 8 | History tag of record |
| stkValid | output | 1 | Return-stack command strobe |
| stkOp | output | 1 | 0 restore, 1 pop |
| stkIdx | output | 4 | Slot to restore |
| stkVal | output | 32 | Address to restore |
| tgtValid | output | 1 | Target-buffer update strobe |
| tgtPc | output | 32 | PC to update |
| tgtTarget | output | 32 | Corrected target |
| mispredCount | output | 16 | Misprediction count |
| stackWrongCount | output | 16 | Repairs of stack-using records |

## Verification
The bench runs squashes over records of every stack kind: stack users, calls that pushed, and plain conditional branches. Comparing the stack command stream against the model shows whether the restore-before-pop priority and youngest-first order are right. Mispredictions are tried with both actual directions, on a return that skipped the stack, on a stack user and on a pushing call. Later squashes and commits of the repaired records then show whether the in-place flag changes stuck, since a stale flag reappears as an extra stack command or as train instead of retire. A full queue, inserts offered while full or busy, and a misprediction on an empty queue separate a correct design from one that drops boundary conditions.

// File: rtl/hist_repair_pkg.sv
package hist_repair_pkg;
  localparam int SEQ_W = 16;
  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int TAG_W = 8;

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic [PC_W-1:0]  pc;
    logic             predTaken;
    logic [IDX_W-1:0] stkIdx;
    logic [PC_W-1:0]  stkVal;
    logic             usedStack;
    logic             pushed;
    logic             wasCall;
    logic             wasReturn;
    logic             wasSquashed;
    logic [TAG_W-1:0] tag;
  } histRec_t;

  typedef struct packed {
    logic push;
    logic popOld;
    logic popYoung;
    logic fixYoung;
    logic fixUsed;
    logic fixPushed;
  } qStrobe_t;

  typedef enum logic [1:0] {PRED_TRAIN = 2'd0, PRED_RETIRE = 2'd1, PRED_DISCARD = 2'd2} predOp_e;
  typedef enum logic {STK_RESTORE = 1'b0, STK_POP = 1'b1} stkOp_e;
endpackage

// File: rtl/hist_queue_dp.sv
module hist_queue_dp
  import hist_repair_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_QW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strb,
  input  histRec_t          insRec,
  output histRec_t          oldRec,
  output histRec_t          youngRec,
  output logic [CNT_QW-1:0] count
);
  histRec_t mem [DEPTH];
  logic [PTR_W-1:0] headPtr, tailPtr, youngIdx;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign youngIdx = (tailPtr == '0) ? PTR_W'(DEPTH - 1) : tailPtr - PTR_W'(1);
  assign oldRec   = mem[headPtr];
  assign youngRec = mem[youngIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strb.push) begin
        tailPtr <= bump(tailPtr);
        count   <= count + CNT_QW'(1);
      end else if (strb.popOld) begin
        headPtr <= bump(headPtr);
        count   <= count - CNT_QW'(1);
      end else if (strb.popYoung) begin
        tailPtr <= youngIdx;
        count   <= count - CNT_QW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) begin
      mem[tailPtr] <= insRec;
    end else if (strb.fixYoung) begin
      mem[youngIdx].wasSquashed <= 1'b1;
      mem[youngIdx].usedStack   <= strb.fixUsed;
      mem[youngIdx].pushed      <= strb.fixPushed;
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> count < CNT_QW'(DEPTH));
  assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> count == $past(count) + CNT_QW'(1));
  assert_pop_shrinks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popOld || strb.popYoung) |=> count == $past(count) - CNT_QW'(1));
  assert_one_action_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.push, strb.popOld, strb.popYoung, strb.fixYoung}));
endmodule

// File: rtl/hist_queue_ctl.sv
module hist_queue_ctl
  import hist_repair_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int CNT_QW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  output logic              insReady,
  input  logic              commitValid,
  input  logic [SEQ_W-1:0]  commitSeq,
  input  logic              squashValid,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              squashMispred,
  input  logic              actTaken,
  input  logic [PC_W-1:0]   corrTarget,
  input  histRec_t          oldRec,
  input  histRec_t          youngRec,
  input  logic [CNT_QW-1:0] count,
  output qStrobe_t          strb,
  output logic              busy,
  output logic              predValid,
  output logic [1:0]        predOp,
  output logic [PC_W-1:0]   predPc,
  output logic              predTaken,
  output logic              predSquashed,
  output logic [TAG_W-1:0]  predTag,
  output logic              stkValid,
  output logic              stkOp,
  output logic [IDX_W-1:0]  stkIdx,
  output logic [PC_W-1:0]   stkVal,
  output logic              tgtValid,
  output logic [PC_W-1:0]   tgtPc,
  output logic [PC_W-1:0]   tgtTarget,
  output logic [CNT_W-1:0]  mispredCount,
  output logic [CNT_W-1:0]  stackWrongCount
);
  typedef enum logic [1:0] {ST_IDLE, ST_COMMIT, ST_SQUASH} walkState_e;
  walkState_e state;
  logic [SEQ_W-1:0] boundSeq;
  logic misReg, actReg;
  logic [PC_W-1:0] corrReg;
  logic notEmpty, commitPop, squashPop, repairNow;

  assign notEmpty  = (count != '0);
  assign commitPop = (state == ST_COMMIT) && notEmpty && (oldRec.seq <= boundSeq);
  assign squashPop = (state == ST_SQUASH) && notEmpty && (youngRec.seq > boundSeq);
  assign repairNow = (state == ST_SQUASH) && !squashPop && misReg && notEmpty;
  assign busy      = (state != ST_IDLE);
  assign insReady  = !busy && (count != CNT_QW'(DEPTH)) && !commitValid && !squashValid;

  always_comb begin
    strb = '0;
    strb.push = insValid && insReady;
    predValid = 1'b0; predOp = PRED_TRAIN; predPc = '0; predTaken = 1'b0;
    predSquashed = 1'b0; predTag = '0;
    stkValid = 1'b0; stkOp = STK_RESTORE; stkIdx = '0; stkVal = '0;
    tgtValid = 1'b0; tgtPc = '0; tgtTarget = '0;
    if (commitPop) begin
      strb.popOld = 1'b1;
      predValid = 1'b1;
      predOp    = oldRec.wasSquashed ? PRED_RETIRE : PRED_TRAIN;
      predPc    = oldRec.pc;
      predTaken = oldRec.predTaken;
      predTag   = oldRec.tag;
    end else if (squashPop) begin
      strb.popYoung = 1'b1;
      predValid = 1'b1;
      predOp    = PRED_DISCARD;
      predPc    = youngRec.pc;
      predTaken = youngRec.predTaken;
      predTag   = youngRec.tag;
      if (youngRec.usedStack) begin
        stkValid = 1'b1; stkOp = STK_RESTORE;
        stkIdx = youngRec.stkIdx; stkVal = youngRec.stkVal;
      end else if (youngRec.wasCall && youngRec.pushed) begin
        stkValid = 1'b1; stkOp = STK_POP;
      end
    end else if (repairNow) begin
      strb.fixYoung  = 1'b1;
      strb.fixUsed   = youngRec.usedStack;
      strb.fixPushed = youngRec.pushed;
      predValid    = 1'b1;
      predOp       = PRED_TRAIN;
      predPc       = youngRec.pc;
      predTaken    = actReg;
      predSquashed = 1'b1;
      predTag      = youngRec.tag;
      if (actReg) begin
        if (youngRec.wasReturn && !youngRec.usedStack) begin
          stkValid = 1'b1; stkOp = STK_POP;
          strb.fixUsed = 1'b1;
        end
        tgtValid = 1'b1; tgtPc = youngRec.pc; tgtTarget = corrReg;
      end else if (youngRec.usedStack) begin
        stkValid = 1'b1; stkOp = STK_RESTORE;
        stkIdx = youngRec.stkIdx; stkVal = youngRec.stkVal;
        strb.fixUsed = 1'b0;
      end else if (youngRec.wasCall && youngRec.pushed) begin
        stkValid = 1'b1; stkOp = STK_POP;
        strb.fixPushed = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      boundSeq <= '0; misReg <= 1'b0; actReg <= 1'b0; corrReg <= '0;
      mispredCount <= '0; stackWrongCount <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (squashValid) begin
            state <= ST_SQUASH;
            boundSeq <= squashSeq; misReg <= squashMispred;
            actReg <= actTaken; corrReg <= corrTarget;
            if (squashMispred) mispredCount <= mispredCount + CNT_W'(1);
          end else if (commitValid) begin
            state <= ST_COMMIT;
            boundSeq <= commitSeq; misReg <= 1'b0;
          end
        end
        ST_COMMIT: if (!commitPop) state <= ST_IDLE;
        default: begin
          if (!squashPop) state <= ST_IDLE;
          if (repairNow && youngRec.usedStack)
            stackWrongCount <= stackWrongCount + CNT_W'(1);
        end
      endcase
    end
  end

  assert_mispred_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (mispredCount == $past(mispredCount)) ||
             (mispredCount == $past(mispredCount) + CNT_W'(1)));
  assert_stack_wrong_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    stackWrongCount <= mispredCount);
  assert_tgt_taken_R8: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid |-> (predValid && predTaken && predSquashed));
  assert_idle_after_walk_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !predValid) |=> !busy);
endmodule

// File: rtl/hist_repair_queue.sv
module hist_repair_queue
  import hist_repair_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int CNT_QW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  output logic              insReady,
  input  logic [SEQ_W-1:0]  insSeq,
  input  logic [PC_W-1:0]   insPc,
  input  logic              insTaken,
  input  logic [IDX_W-1:0]  insStkIdx,
  input  logic [PC_W-1:0]   insStkVal,
  input  logic              insUsedStack,
  input  logic              insPushed,
  input  logic              insWasCall,
  input  logic              insWasReturn,
  input  logic [TAG_W-1:0]  insTag,
  input  logic              commitValid,
  input  logic [SEQ_W-1:0]  commitSeq,
  input  logic              squashValid,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              squashMispred,
  input  logic              actTaken,
  input  logic [PC_W-1:0]   corrTarget,
  output logic              busy,
  output logic              predValid,
  output logic [1:0]        predOp,
  output logic [PC_W-1:0]   predPc,
  output logic              predTaken,
  output logic              predSquashed,
  output logic [TAG_W-1:0]  predTag,
  output logic              stkValid,
  output logic              stkOp,
  output logic [IDX_W-1:0]  stkIdx,
  output logic [PC_W-1:0]   stkVal,
  output logic              tgtValid,
  output logic [PC_W-1:0]   tgtPc,
  output logic [PC_W-1:0]   tgtTarget,
  output logic [CNT_W-1:0]  mispredCount,
  output logic [CNT_W-1:0]  stackWrongCount
);
  histRec_t insRec, oldRec, youngRec;
  qStrobe_t strb;
  logic [CNT_QW-1:0] count;

  assign insRec = '{seq: insSeq, pc: insPc, predTaken: insTaken, stkIdx: insStkIdx,
                    stkVal: insStkVal, usedStack: insUsedStack, pushed: insPushed,
                    wasCall: insWasCall, wasReturn: insWasReturn, wasSquashed: 1'b0,
                    tag: insTag};

  hist_queue_dp #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .insRec(insRec),
    .oldRec(oldRec), .youngRec(youngRec), .count(count));

  hist_queue_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insReady(insReady),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .squashValid(squashValid), .squashSeq(squashSeq), .squashMispred(squashMispred),
    .actTaken(actTaken), .corrTarget(corrTarget),
    .oldRec(oldRec), .youngRec(youngRec), .count(count), .strb(strb), .busy(busy),
    .predValid(predValid), .predOp(predOp), .predPc(predPc), .predTaken(predTaken),
    .predSquashed(predSquashed), .predTag(predTag),
    .stkValid(stkValid), .stkOp(stkOp), .stkIdx(stkIdx), .stkVal(stkVal),
    .tgtValid(tgtValid), .tgtPc(tgtPc), .tgtTarget(tgtTarget),
    .mispredCount(mispredCount), .stackWrongCount(stackWrongCount));
endmodule

// File: tb/tb_hist_repair_queue.sv
module tb_hist_repair_queue;
  import hist_repair_pkg::*;

  logic clk = 1'b0, rstN = 1'b0;
  always #4 clk = ~clk;

  logic insValid = 0, insTaken = 0, insUsedStack = 0, insPushed = 0, insWasCall = 0, insWasReturn = 0;
  logic [15:0] insSeq = 0, commitSeq = 0, squashSeq = 0;
  logic [31:0] insPc = 0, insStkVal = 0, corrTarget = 0;
  logic [3:0] insStkIdx = 0;
  logic [7:0] insTag = 0;
  logic commitValid = 0, squashValid = 0, squashMispred = 0, actTaken = 0;
  logic insReady, busy, predValid, predTaken, predSquashed, stkValid, stkOp, tgtValid;
  logic [1:0] predOp;
  logic [31:0] predPc, stkVal, tgtPc, tgtTarget;
  logic [7:0] predTag;
  logic [3:0] stkIdx;
  logic [15:0] mispredCount, stackWrongCount;

  hist_repair_queue dut (.*);

  typedef struct {int cls; logic [1:0] op; logic [31:0] a; logic [31:0] b; string req;} ev_t;
  ev_t expQ[$];
  histRec_t model[$];
  int nChecks = 0, nFails = 0;
  int expMis = 0, expStkWrong = 0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void expPred(logic [1:0] op, histRec_t r, logic tk, logic sq, string req);
    expQ.push_back('{1, op, r.pc, {22'd0, r.tag, tk, sq}, req});
  endfunction
  function automatic void expStk(logic op, logic [3:0] idx, logic [31:0] val, string req);
    expQ.push_back('{2, {1'b0, op}, {28'd0, idx}, val, req});
  endfunction

  task automatic observe(int cls, logic [1:0] op, logic [31:0] a, logic [31:0] b);
    ev_t e;
    nChecks++;
    if (expQ.size() == 0) begin
      nFails++;
      $display("FAIL R4 unexpected command class %0d: actual op %0d expected none", cls, op);
    end else begin
      e = expQ.pop_front();
      nChecks--;
      check(e.req, "command", {cls[3:0], op, a, b[25:0]}, {e.cls[3:0], e.op, e.a, e.b[25:0]});
    end
  endtask

  // monitor
  always @(negedge clk) if (rstN) begin
    if (predValid) observe(1, predOp, predPc, {22'd0, predTag, predTaken, predSquashed});
    if (stkValid)  observe(2, {1'b0, stkOp}, {28'd0, stkIdx}, stkVal);
    if (tgtValid)  observe(3, 2'd0, tgtPc, tgtTarget);
  end

  task automatic doInsert(int sq, bit tk, bit used, bit push, bit call, bit ret);
    histRec_t r;
    r = '{seq: 16'(sq), pc: 32'h1000 + 32'(sq) * 4, predTaken: tk, stkIdx: 4'(sq),
          stkVal: 32'hA000 + 32'(sq), usedStack: used, pushed: push, wasCall: call,
          wasReturn: ret, wasSquashed: 1'b0, tag: 8'(sq * 3)};
    @(negedge clk);
    while (!insReady) @(negedge clk);
    insValid = 1; insSeq = r.seq; insPc = r.pc; insTaken = tk; insStkIdx = r.stkIdx;
    insStkVal = r.stkVal; insUsedStack = used; insPushed = push; insWasCall = call;
    insWasReturn = ret; insTag = r.tag;
    @(negedge clk);
    insValid = 0;
    model.push_back(r);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic doCommit(int done);
    while (model.size() > 0 && model[0].seq <= 16'(done)) begin
      expPred(model[0].wasSquashed ? 2'd1 : 2'd0, model[0], model[0].predTaken, 1'b0, "R3");
      void'(model.pop_front());
    end
    @(negedge clk);
    commitValid = 1; commitSeq = 16'(done);
    @(negedge clk);
    commitValid = 0;
    waitIdle();
  endtask

  task automatic doSquash(int sq, bit mis, bit act, logic [31:0] tgt);
    while (model.size() > 0 && model[$].seq > 16'(sq)) begin
      expPred(2'd2, model[$], model[$].predTaken, 1'b0, "R4");
      if (model[$].usedStack) expStk(1'b0, model[$].stkIdx, model[$].stkVal, "R5");
      else if (model[$].wasCall && model[$].pushed) expStk(1'b1, 4'd0, 32'd0, "R5");
      void'(model.pop_back());
    end
    if (mis) begin
      expMis++;
      if (model.size() > 0) begin
        if (model[$].usedStack) expStkWrong++;
        expPred(2'd0, model[$], act, 1'b1, "R6");
        model[$].wasSquashed = 1'b1;
        if (act) begin
          if (model[$].wasReturn && !model[$].usedStack) begin
            expStk(1'b1, 4'd0, 32'd0, "R8");
            model[$].usedStack = 1'b1;
          end
          expQ.push_back('{3, 2'd0, model[$].pc, tgt, "R8"});
        end else if (model[$].usedStack) begin
          expStk(1'b0, model[$].stkIdx, model[$].stkVal, "R9");
          model[$].usedStack = 1'b0;
        end else if (model[$].wasCall && model[$].pushed) begin
          expStk(1'b1, 4'd0, 32'd0, "R9");
          model[$].pushed = 1'b0;
        end
      end
    end
    @(negedge clk);
    squashValid = 1; squashSeq = 16'(sq); squashMispred = mis; actTaken = act; corrTarget = tgt;
    @(negedge clk);
    squashValid = 0; squashMispred = 0;
    waitIdle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1", "insReady after reset", insReady, 1);
    check("R11", "busy after reset", busy, 0);
    check("R7", "mispredCount after reset", mispredCount, 0);

    // R2/R3: basic commit
    doInsert(1, 1, 0, 0, 0, 0);
    doInsert(2, 0, 0, 1, 1, 0);
    doInsert(3, 1, 0, 0, 0, 0);
    doInsert(4, 1, 1, 0, 0, 1);
    doInsert(5, 1, 0, 1, 1, 0);
    doCommit(2);
    // R4/R5: plain squash, youngest first with stack undo
    doSquash(3, 0, 0, 0);
    // R6/R8: taken repair of return that skipped stack
    doInsert(6, 0, 0, 0, 0, 1);
    doInsert(7, 1, 0, 0, 0, 0);
    doSquash(6, 1, 1, 32'h600);
    doCommit(10);  // 3 trains, 6 retires (R3, R6)
    // R9: not-taken repairs
    doInsert(8, 1, 0, 1, 1, 0);
    doInsert(9, 1, 1, 0, 0, 1);
    doSquash(9, 1, 0, 0);
    doSquash(8, 1, 0, 0);
    doSquash(7, 0, 0, 0);
    // R10: empty mispredict
    doSquash(7, 1, 1, 32'h777);
    check("R7", "mispredCount", mispredCount, 16'(expMis));
    check("R7", "stackWrongCount", stackWrongCount, 16'(expStkWrong));

    // R1: fill the queue
    for (int i = 0; i < 16; i++) doInsert(20 + i, i % 2, 0, 0, 0, 0);
    @(negedge clk);
    check("R1", "insReady when full", insReady, 0);
    insValid = 1; insSeq = 16'd99;
    @(negedge clk);
    insValid = 0;
    // R11: busy blocks insertion during walk
    for (int i = 0; i < 16; i++) begin
      expPred(2'd0, model[0], model[0].predTaken, 1'b0, "R2");
      void'(model.pop_front());
    end
    commitValid = 1; commitSeq = 16'd200;
    @(negedge clk);
    commitValid = 0;
    check("R11", "busy during commit walk", busy, 1);
    check("R11", "insReady during walk", insReady, 0);
    insValid = 1; insSeq = 16'd98;
    @(negedge clk);
    insValid = 0;
    waitIdle();
    // R10: queue must now be empty, so mispredict emits nothing
    doSquash(0, 1, 0, 0);
    check("R7", "mispredCount final", mispredCount, 16'(expMis));
    repeat (3) @(negedge clk);
    check("R10", "leftover expected commands", 64'(expQ.size()), 0);
    check("R1", "insReady at end", insReady, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule